// File: doc/BRIEF.md
# Strobed Register Bank with Wait-State Control on an APB Completer Port

This block sits on the completer side of an APB segment and holds a small set of 32-bit registers. It has a parameterised number of general control words, each exported to the surrounding logic. It also has one word that sets the response latency, and one sticky event word that clears when it is read. The requester reaches all of them through ordinary two-phase APB transfers.

Address decode, write-enable generation and the read multiplexer are active only while the block is selected. A transfer has an effect only on the clock edge where select, enable and ready are all high. The block stretches every ACCESS phase by the number of wait cycles programmed in its latency word. Writes merge byte lanes under the write strobes. A misaligned, unmapped or read-only target is answered with an error response and blocks the register update.

Top module: `regbank_apb`

## Requirements
- R1: While `psel` is low, or before the edge where `psel`, `penable` and `pready` are all high, no register changes. In that state `pready`, `pslverr` and `prdata` stay low or zero.
- R2: Let N be the value of the lowest `WS_W` bits of the latency word, as held at the SETUP cycle. `pready` is then low for the first N ACCESS cycles and high in ACCESS cycle N+1.
- R3: With N equal to zero, `pready` is high in the first ACCESS cycle, so a transfer takes one SETUP cycle and one ACCESS cycle.
- R4: On a successful write, bit k of `pstrb` enables byte lane k, which is bits 8k+7 down to 8k of `pwdata`. Lanes with a strobe of zero keep their previous contents.
- R5: In the completion cycle of a successful read, `prdata` carries the addressed register. In every other cycle, and on an errored read, `prdata` is zero.
- R6: An access whose `paddr[1:0]` is not zero completes with `pslverr` high, and a write of this kind changes no register.
- R7: The word index is `paddr >> 2`. An access whose word index is above NUM_GP+1 completes with `pslverr` high, and a write of this kind changes no register.
- R8: A write to the event word, at byte address 4*(NUM_GP+1), completes with `pslverr` high and leaves the event word unchanged.
- R9: A bit of the event word is set by a one-cycle pulse on the matching bit of `evt_set` and stays set. The completion cycle of a successful read of the event word clears exactly the bits returned by that read. An event pulse that arrives in that same cycle remains set.
- R10: The general words sit at byte addresses 4*i for i below NUM_GP, and the latency word sits at 4*NUM_GP. All registers reset to zero, and `gp_q[32*i+31:32*i]` mirrors general word i.
- R11: `pslverr` is low in every cycle that is not a completion cycle, including the wait cycles of a transfer that will end in an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | ACCESS phase marker |
| paddr | input | ADDR_W | Byte address |
| pwrite | input | 1 | High for write, low for read |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte-lane enables |
| prdata | output | 32 | Read data, non-zero only in a successful read completion |
| pready | output | 1 | Completion permitted in this ACCESS cycle |
| pslverr | output | 1 | Error response, valid in the completion cycle |
| evt_set | input | 32 | One-cycle event pulses into the event word |
| gp_q | output | 32*NUM_GP | Exported general control words |

## Verification
A read of the event word and the arrival of a new event pulse can fall in the same clock edge. The clear from the read and the set from the pulse then act on the event word together. The bench provokes this by raising an `evt_set` bit during the completion cycle of a read of the event word. The read must return only the old bits, and a following read must return just the new bit. A second pairing comes from a latency word that is non-zero while the address is illegal. Here the wait stretching and the error response meet in one transfer, so `pslverr` must stay low through every wait cycle and rise only in the completion cycle.

// File: rtl/regbank_pkg.sv
// Shared widths and the access-phase type for the register bank.
// Assumes a 32-bit data path split into 8-bit lanes.
package regbank_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int STRB_W = DATA_W / LANE_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [STRB_W-1:0] strb_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;
endpackage

// File: rtl/regbank_apb_ready.sv
// Wait-state generator. It loads the programmed count in the SETUP cycle
// and counts it down through the ACCESS cycles. Ready is raised once the
// count reaches zero. It assumes the requester keeps psel and penable high
// until ready.
module regbank_apb_ready
    import regbank_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psel,
    input  logic            penable,
    input  logic [WS_W-1:0] wait_cfg,
    output logic            ready
);
    phase_e          phase;
    logic [WS_W-1:0] cnt_q;

    // Classify the current bus cycle
    always_comb begin
        if (!psel)         phase = PH_IDLE;
        else if (!penable) phase = PH_SETUP;
        else               phase = PH_ACCESS;
    end

    // Load in SETUP, decrement through waited ACCESS cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (phase == PH_SETUP)                cnt_q <= wait_cfg;
        else if (phase == PH_ACCESS && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (phase == PH_ACCESS) && (cnt_q == '0);

    // R3
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && wait_cfg == '0) |=> (!(psel && penable) || ready));

    // R2
    first_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable && wait_cfg != '0) |=> !ready);
endmodule

// File: rtl/regbank_apb_decode.sv
// Address decoder. It turns a byte address into one-hot register selects
// and an error flag. Every output is forced inactive while unselected, so
// no decode activity reaches the register logic. It assumes word-aligned
// registers placed one after another from address zero.
module regbank_apb_decode #(
    parameter int ADDR_W = 8,
    parameter int NUM_GP = 2
) (
    input  logic              psel,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_GP-1:0] sel_gp,
    output logic              sel_wait,
    output logic              sel_evt,
    output logic              bad
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] WAIT_IDX = IDX_W'(NUM_GP);
    localparam logic [IDX_W-1:0] EVT_IDX  = IDX_W'(NUM_GP + 1);

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // One-hot selects for the general words
    genvar gi;
    generate
        for (gi = 0; gi < NUM_GP; gi++) begin : g_sel
            assign sel_gp[gi] = psel && aligned && (idx == IDX_W'(gi));
        end
    endgenerate

    // Selects for the latency and event words, then the error policy
    always_comb begin
        sel_wait = psel && aligned && (idx == WAIT_IDX);
        sel_evt  = psel && aligned && (idx == EVT_IDX);
        bad      = psel && (!aligned || (idx > EVT_IDX) || (is_write && idx == EVT_IDX));
    end
endmodule

// File: rtl/regbank_apb_word.sv
// One storage word with per-lane write enables. A lane is updated only
// when the word is written and its strobe bit is set.
module regbank_apb_word
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  strb_t strb,
    input  word_t wdata,
    output word_t q
);
    genvar li;
    generate
        for (li = 0; li < STRB_W; li++) begin : g_lane
            // Update one byte lane under its strobe
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[li*LANE_W +: LANE_W] <= '0;
                else if (we && strb[li])
                    q[li*LANE_W +: LANE_W] <= wdata[li*LANE_W +: LANE_W];
            end
        end
    endgenerate

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

    // R4
    lane0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !strb[0]) |=> (q[LANE_W-1:0] == $past(q[LANE_W-1:0])));
endmodule

// File: rtl/regbank_apb_event.sv
// Sticky event word. Pulses set bits. A read completion clears the bits
// that the read returned, and a pulse that arrives in the same cycle wins.
module regbank_apb_event
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_in,
    input  logic  rd_clr,
    output word_t q
);
    // Accumulate events, drop the bits that were just read out
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (rd_clr) q <= set_in;
        else             q <= q | set_in;
    end

    // R9
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/regbank_apb.sv
// APB completer holding NUM_GP general words, a latency word and a
// clear-on-read event word. It assumes a requester that follows the
// SETUP then ACCESS order and keeps the transfer stable while waited.
module regbank_apb
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_GP = 2,
    parameter int WS_W   = 4
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic                pwrite,
    input  logic [31:0]         pwdata,
    input  logic [3:0]          pstrb,
    output logic [31:0]         prdata,
    output logic                pready,
    output logic                pslverr,
    input  logic [31:0]         evt_set,
    output logic [32*NUM_GP-1:0] gp_q
);
    logic [NUM_GP-1:0] sel_gp;
    logic              sel_wait, sel_evt, bad;
    logic              done, wr_ok, rd_ok;
    word_t             gp_arr [NUM_GP];
    word_t             wait_q, evt_q, rd_mux;

    regbank_apb_decode #(.ADDR_W(ADDR_W), .NUM_GP(NUM_GP)) u_dec (
        .psel(psel), .is_write(pwrite), .addr(paddr),
        .sel_gp(sel_gp), .sel_wait(sel_wait), .sel_evt(sel_evt), .bad(bad)
    );

    regbank_apb_ready #(.WS_W(WS_W)) u_rdy (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .wait_cfg(wait_q[WS_W-1:0]), .ready(pready)
    );

    // Completion qualifiers for the register updates and the response
    always_comb begin
        done  = psel && penable && pready;
        wr_ok = done && pwrite && !bad;
        rd_ok = done && !pwrite && !bad;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_GP; gi++) begin : g_gp
            regbank_apb_word u_word (
                .clk(pclk), .rst_n(presetn), .we(wr_ok && sel_gp[gi]),
                .strb(pstrb), .wdata(pwdata), .q(gp_arr[gi])
            );
            assign gp_q[gi*32 +: 32] = gp_arr[gi];
        end
    endgenerate

    regbank_apb_word u_wait (
        .clk(pclk), .rst_n(presetn), .we(wr_ok && sel_wait),
        .strb(pstrb), .wdata(pwdata), .q(wait_q)
    );

    regbank_apb_event u_evt (
        .clk(pclk), .rst_n(presetn), .set_in(evt_set),
        .rd_clr(rd_ok && sel_evt), .q(evt_q)
    );

    // Read multiplexer, quiet unless a word is selected
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_GP; i++)
            if (sel_gp[i]) rd_mux = gp_arr[i];
        if (sel_wait) rd_mux = wait_q;
        if (sel_evt)  rd_mux = evt_q;
    end

    // Response outputs, driven only in the completion cycle
    always_comb begin
        prdata  = rd_ok ? rd_mux : '0;
        pslverr = done && bad;
    end

    // R6 R7
    err_write_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (done && pwrite && bad) |=> ($stable(gp_q) && $stable(wait_q)));

    // R11
    err_late_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pready) |-> !pslverr);
endmodule

// File: tb/regbank_apb_tb.sv
// Directed bench for regbank_apb: one task per scenario, each checking itself.
module regbank_apb_tb;
    localparam int ADDR_W = 8;
    localparam int NUM_GP = 2;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0] pwdata = '0, evt_set = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [32*NUM_GP-1:0] gp_q;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_gp [NUM_GP];
    logic [31:0] m_wait;

    regbank_apb #(.ADDR_W(ADDR_W), .NUM_GP(NUM_GP), .WS_W(4)) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .evt_set(evt_set), .gp_q(gp_q)
    );

    always #4 pclk = ~pclk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer; waits, data and error are returned; pulse goes onto evt_set in the completion cycle
    task automatic xfer(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic [31:0] pulse,
                        output logic [31:0] rd, output logic err, output int waits);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        #1;
        chk(!pready && !pslverr && prdata == 0, "R1 setup quiet", {29'd0, pready, pslverr, |prdata}, 0);
        @(negedge pclk);
        penable = 1'b1;
        #1;
        waits = 0;
        while (!pready) begin
            chk(!pslverr && prdata == 0, "R11 wait cycle quiet", {31'd0, pslverr}, 0);
            waits++;
            @(negedge pclk);
            #1;
        end
        rd = prdata; err = pslverr;
        evt_set = pulse;
        @(negedge pclk);
        evt_set = '0; psel = 1'b0; penable = 1'b0;
    endtask

    task automatic chk_gp(input string req);
        for (int i = 0; i < NUM_GP; i++)
            chk(gp_q[i*32 +: 32] === m_gp[i], req, gp_q[i*32 +: 32], m_gp[i]);
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic err; int w;
        chk(!pready && !pslverr && prdata == 0, "R1 reset outputs", prdata, 0);
        chk_gp("R10 reset gp_q");
        for (int i = 0; i <= NUM_GP + 1; i++) begin
            xfer(1'b0, ADDR_W'(4*i), 0, 0, 0, rd, err, w);
            chk(rd == 0 && !err, "R10 reset read", rd, 0);
        end
    endtask

    task automatic t_basic();
        logic [31:0] rd; logic err; int w;
        xfer(1'b1, 8'h00, 32'hA5A5_1234, 4'hF, 0, rd, err, w);
        m_gp[0] = 32'hA5A5_1234;
        chk(w == 0 && !err, "R3 zero waits write", w, 0);
        xfer(1'b1, 8'h04, 32'h0BAD_F00D, 4'hF, 0, rd, err, w);
        m_gp[1] = 32'h0BAD_F00D;
        chk_gp("R10 gp_q mirror");
        xfer(1'b0, 8'h04, 0, 0, 0, rd, err, w);
        chk(rd == m_gp[1], "R5 read gp1", rd, m_gp[1]);
        chk(w == 0, "R3 zero waits read", w, 0);
        xfer(1'b0, 8'h00, 0, 0, 0, rd, err, w);
        chk(rd == m_gp[0], "R5 read gp0", rd, m_gp[0]);
    endtask

    task automatic t_strobe();
        logic [31:0] rd; logic err; int w;
        xfer(1'b1, 8'h00, 32'h1122_3344, 4'b0101, 0, rd, err, w);
        m_gp[0] = {m_gp[0][31:24], 8'h22, m_gp[0][15:8], 8'h44};
        chk_gp("R4 strobe 0101");
        xfer(1'b1, 8'h04, 32'hFFEE_DDCC, 4'b1000, 0, rd, err, w);
        m_gp[1] = {8'hFF, m_gp[1][23:0]};
        chk_gp("R4 strobe 1000");
        xfer(1'b1, 8'h04, 32'h5555_5555, 4'b0000, 0, rd, err, w);
        chk_gp("R4 strobe none");
    endtask

    task automatic t_waits();
        logic [31:0] rd; logic err; int w;
        xfer(1'b1, 8'h08, 32'd3, 4'hF, 0, rd, err, w);
        m_wait = 32'd3;
        chk(w == 0, "R3 old latency used", w, 0);
        xfer(1'b0, 8'h04, 0, 0, 0, rd, err, w);
        chk(w == 3, "R2 three waits", w, 3);
        chk(rd == m_gp[1], "R5 waited read data", rd, m_gp[1]);
        xfer(1'b1, 8'h08, 32'hABCD_0025, 4'hF, 0, rd, err, w);
        m_wait = 32'hABCD_0025;
        xfer(1'b0, 8'h08, 0, 0, 0, rd, err, w);
        chk(w == 5, "R2 low bits only", w, 5);
        chk(rd == m_wait, "R10 latency readback", rd, m_wait);
    endtask

    task automatic t_errors();
        logic [31:0] rd; logic err; int w;
        xfer(1'b1, 8'h01, 32'hDEAD_BEEF, 4'hF, 0, rd, err, w);
        chk(err, "R6 misaligned write err", err, 1);
        chk_gp("R6 misaligned no update");
        xfer(1'b0, 8'h06, 0, 0, 0, rd, err, w);
        chk(err && rd == 0, "R6 misaligned read err", rd, 0);
        xfer(1'b1, 8'h10, 32'hDEAD_BEEF, 4'hF, 0, rd, err, w);
        chk(err && w == 5, "R7 unmapped write err with waits", w, 5);
        chk_gp("R7 unmapped no update");
        xfer(1'b0, 8'hFC, 0, 0, 0, rd, err, w);
        chk(err && rd == 0, "R7 unmapped read zero", rd, 0);
        xfer(1'b1, 8'h0C, 32'hFFFF_FFFF, 4'hF, 0, rd, err, w);
        chk(err, "R8 event write err", err, 1);
        xfer(1'b0, 8'h0C, 0, 0, 0, rd, err, w);
        chk(rd == 0 && !err, "R8 event unchanged", rd, 0);
        xfer(1'b0, 8'h08, 0, 0, 0, rd, err, w);
        chk(rd == m_wait, "R7 latency kept", rd, m_wait);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 6; i++) begin
            @(negedge pclk);
            psel = 1'b0; penable = (i % 2) == 1; pwrite = 1'b1;
            paddr = ADDR_W'(4 * (i % 3)); pwdata = 32'hFFFF_FFFF; pstrb = 4'hF;
            #1;
            chk(!pready && !pslverr && prdata == 0, "R1 unselected quiet", prdata, 0);
        end
        @(negedge pclk);
        penable = 1'b0;
        chk_gp("R1 unselected no update");
    endtask

    task automatic t_event();
        logic [31:0] rd; logic err; int w;
        @(negedge pclk); evt_set = 32'h0000_0081;
        @(negedge pclk); evt_set = 32'h0000_0100;
        @(negedge pclk); evt_set = '0;
        xfer(1'b0, 8'h0C, 0, 0, 32'h0004_0000, rd, err, w);
        chk(rd == 32'h0000_0181, "R9 sticky read", rd, 32'h0000_0181);
        xfer(1'b0, 8'h0C, 0, 0, 0, rd, err, w);
        chk(rd == 32'h0004_0000, "R9 same-cycle set survives", rd, 32'h0004_0000);
        xfer(1'b0, 8'h0C, 0, 0, 0, rd, err, w);
        chk(rd == 0, "R9 cleared after read", rd, 0);
    endtask

    initial begin
        m_gp[0] = '0; m_gp[1] = '0; m_wait = '0;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        #1;
        t_reset();
        t_basic();
        t_strobe();
        t_idle();
        t_waits();
        t_errors();
        t_event();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge pclk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule